// File: doc/BRIEF.md
# SMBus Bus Watch

A passive observer for a two-wire SMBus segment. It never drives the lines. It samples the clock and data wires into the system clock domain and filters out short spikes. From the cleaned levels it decodes start, repeated start and stop conditions and keeps a busy/free view of the bus. It also measures how long the clock is held low and flags the timing faults that SMBus adds on top of plain I2C. These faults are a clock held low too long and excessive clock stretching, counted once over a whole message and once inside a single byte. It also raises a warning when a clock phase is slower than the lowest legal bus frequency, and it reports when both wires have been high long enough for the bus to count as free.

All limits are parameters counted in system clock cycles. The defaults assume a 50 MHz system clock: 25 ms timeout, 25 ms message stretch, 10 ms byte stretch, 50 us slow-phase and idle windows, and 5 us nominal low phase. Each fault flag stays set until `clr` is pulsed or reset is applied. The bus-state outputs follow the wires with a fixed latency.

Top module: `smb_bus_watch`

## Requirements
- R1: A level change on either input is accepted only after it has held for FILT_CYC consecutive system cycles once synchronized. A shorter pulse produces no start, no stop and no change of `idle`.
- R2: A falling data edge while the clock is high gives a one-cycle `start_pulse` and sets `bus_busy` on the next cycle.
- R3: A start seen while `bus_busy` is already set also raises `rstart_pulse` in the same cycle. It does not end the message.
- R4: A rising data edge while the clock is high gives a one-cycle `stop_pulse` and clears `bus_busy`.
- R5: When the clock stays low for more than TOUT_CYC cycles, `timeout_flag` sets and `bus_busy` drops. Both stretch totals also return to zero, so `idle` is reported again only after a fresh idle window.
- R6: Each low phase contributes its cycles beyond LOW_NOM_CYC as stretch. Stretch in a byte-boundary low phase counts toward the message total. These are the phase after a start and the phase after each ninth clock of a byte. The message total is cleared only when the bus stops being busy, never by a repeated start. `sext_flag` sets once the total exceeds SEXT_CYC.
- R7: Stretch in the low phases between the first and ninth clock of a byte counts toward a byte total. That total is cleared at every ninth rising clock edge and at each start. `mext_flag` sets once it exceeds MEXT_CYC.
- R8: `slow_flag` sets when the clock is low for more than SLOW_CYC cycles, or high for more than SLOW_CYC cycles while busy. A long high level on a free bus does not set it.
- R9: `idle` is high once both lines have been high for more than IDLE_CYC consecutive cycles, and it drops as soon as either line goes low. Reaching idle also clears `bus_busy`.
- R10: `timeout_flag`, `sext_flag`, `mext_flag` and `slow_flag` hold their value until `clr` is high at a clock edge. `clr` clears them, unless a new fault is detected in that same cycle.
- R11: After reset, all flags, pulses, `bus_busy` and `idle` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky fault flags |
| scl_in | input | 1 | Raw bus clock wire level |
| sda_in | input | 1 | Raw bus data wire level |
| bus_busy | output | 1 | A message is in progress |
| start_pulse | output | 1 | One-cycle marker of any start condition |
| rstart_pulse | output | 1 | One-cycle marker of a start while busy |
| stop_pulse | output | 1 | One-cycle marker of a stop condition |
| idle | output | 1 | Both lines high for longer than the idle window |
| timeout_flag | output | 1 | Sticky clock-low timeout |
| sext_flag | output | 1 | Sticky message-level stretch violation |
| mext_flag | output | 1 | Sticky byte-level stretch violation |
| slow_flag | output | 1 | Sticky slow clock phase warning |

## Verification
The embedded properties assume the wires change only at a pace the filter can follow. They also assume a timeout can never coincide with a start, because a start needs the clock high while a timeout needs it low. The stimulus holds every driven level for at least three filter lengths and moves data only a few cycles after the clock has fallen. It keeps random low phases below the slow-phase and timeout limits, so those two faults appear only in directed sequences. Randomised messages vary the low phase lengths, byte counts and repeated starts. The expected stretch totals for each message are computed from the lengths driven.

// File: rtl/smb_bus_watch.sv
module smb_bus_watch #(
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned LOW_NOM_CYC = 250,
  parameter int unsigned TOUT_CYC    = 1250000,
  parameter int unsigned SEXT_CYC    = 1250000,
  parameter int unsigned MEXT_CYC    = 500000,
  parameter int unsigned SLOW_CYC    = 2500,
  parameter int unsigned IDLE_CYC    = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl_in,
  input  logic sda_in,
  output logic bus_busy,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse,
  output logic idle,
  output logic timeout_flag,
  output logic sext_flag,
  output logic mext_flag,
  output logic slow_flag
);

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned MAXV = umax(umax(umax(TOUT_CYC, SEXT_CYC), umax(MEXT_CYC, SLOW_CYC)),
                                      umax(IDLE_CYC, LOW_NOM_CYC));
  localparam int CW = $clog2(MAXV + 2);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] TOP    = CW'(MAXV + 1);
  localparam logic [CW-1:0] TOUT_V = CW'(TOUT_CYC);
  localparam logic [CW-1:0] SEXT_V = CW'(SEXT_CYC);
  localparam logic [CW-1:0] MEXT_V = CW'(MEXT_CYC);
  localparam logic [CW-1:0] SLOW_V = CW'(SLOW_CYC);
  localparam logic [CW-1:0] IDLE_V = CW'(IDLE_CYC);
  localparam logic [CW-1:0] NOM_V  = CW'(LOW_NOM_CYC);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  logic [1:0] raw, filt;
  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic m1, m2, f;
    logic [FW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b1; m2 <= 1'b1; f <= 1'b1; run <= '0;
      end else begin
        m1 <= raw[i];
        m2 <= m1;
        if (m2 == f) run <= '0;
        else if (run == FW'(FILT_CYC - 1)) begin
          f   <= m2;
          run <= '0;
        end else run <= run + 1'b1;
      end
    end
    assign filt[i] = f;
  end

  logic scl, sda, scl_q, sda_q;
  assign scl = filt[0];
  assign sda = filt[1];

  logic [CW-1:0] low_cnt, high_cnt, idle_cnt, sacc, macc;
  logic [3:0] bitcnt;
  logic sph;

  assign start_pulse  = scl & scl_q & sda_q & ~sda;
  assign stop_pulse   = scl & scl_q & ~sda_q & sda;
  assign rstart_pulse = start_pulse & bus_busy;
  assign idle         = idle_cnt > IDLE_V;

  logic scl_rise, ack_edge, tout_hit, slow_hit, stretch;
  assign scl_rise = scl & ~scl_q;
  assign ack_edge = bus_busy & scl_rise & (bitcnt == 4'd8);
  assign tout_hit = ~scl & (low_cnt == TOUT_V);
  assign slow_hit = (~scl & (low_cnt == SLOW_V)) | (scl & bus_busy & (high_cnt == SLOW_V));
  assign stretch  = bus_busy & ~scl & (low_cnt >= NOM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      low_cnt <= '0; high_cnt <= '0; idle_cnt <= '0;
      bus_busy <= 1'b0; bitcnt <= '0; sph <= 1'b0;
      sacc <= '0; macc <= '0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      low_cnt  <= scl ? '0 : bump(low_cnt);
      high_cnt <= (!scl || start_pulse) ? '0 : bump(high_cnt);
      idle_cnt <= (scl && sda) ? bump(idle_cnt) : '0;

      if (start_pulse) bus_busy <= 1'b1;
      else if (stop_pulse || tout_hit || idle) bus_busy <= 1'b0;

      if (start_pulse || stop_pulse || tout_hit) bitcnt <= '0;
      else if (bus_busy && scl_rise) bitcnt <= (bitcnt == 4'd8) ? 4'd0 : bitcnt + 4'd1;

      if (start_pulse || ack_edge) sph <= 1'b1;
      else if (scl_rise) sph <= 1'b0;

      if (!bus_busy || tout_hit) sacc <= '0;
      else if (stretch && sph) sacc <= bump(sacc);

      if (!bus_busy || tout_hit || ack_edge || start_pulse) macc <= '0;
      else if (stretch && !sph) macc <= bump(macc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_flag <= 1'b0; sext_flag <= 1'b0; mext_flag <= 1'b0; slow_flag <= 1'b0;
    end else begin
      timeout_flag <= tout_hit       | (timeout_flag & ~clr);
      sext_flag    <= (sacc > SEXT_V) | (sext_flag & ~clr);
      mext_flag    <= (macc > MEXT_V) | (mext_flag & ~clr);
      slow_flag    <= slow_hit       | (slow_flag & ~clr);
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> bus_busy); // R2
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R2
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !bus_busy); // R4
  AST_TOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> !bus_busy); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !clr) |=> timeout_flag); // R10
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> $past(scl && sda)); // R9

endmodule

// File: tb/smb_bus_watch_test.sv
module smb_bus_watch_test;
  localparam int FILT = 2, NOM = 20, TOUT = 300, SEXT = 200, MEXT = 120, SLOW = 150, IDLE = 100;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic bus_busy, start_pulse, rstart_pulse, stop_pulse, idle;
  logic timeout_flag, sext_flag, mext_flag, slow_flag;

  smb_bus_watch #(.FILT_CYC(FILT), .LOW_NOM_CYC(NOM), .TOUT_CYC(TOUT), .SEXT_CYC(SEXT),
    .MEXT_CYC(MEXT), .SLOW_CYC(SLOW), .IDLE_CYC(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scl_in(scl_in), .sda_in(sda_in),
    .bus_busy(bus_busy), .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
    .stop_pulse(stop_pulse), .idle(idle), .timeout_flag(timeout_flag),
    .sext_flag(sext_flag), .mext_flag(mext_flag), .slow_flag(slow_flag));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int n_start = 0, n_rstart = 0, n_stop = 0;
  int e_start = 0, e_rstart = 0, e_stop = 0;
  int s_tot = 0, m_cur = 0;
  bit e_mext = 0;
  logic cur_sda = 1'b1;
  bit done = 0;

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (rstart_pulse) n_rstart++;
    if (stop_pulse) n_stop++;
  end

  function automatic int excess(input int len);
    return (len > NOM) ? len - NOM : 0;
  endfunction

  function automatic bit over(input int total, input int lim);
    return total > lim;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic c, input logic d, input int n);
    scl_in = c; sda_in = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic low_phase(input int len, input logic d, input bit slave);
    hold(1'b0, cur_sda, 3);
    hold(1'b0, d, len - 3);
    cur_sda = d;
    if (slave) s_tot += excess(len);
    else m_cur += excess(len);
  endtask

  task automatic do_start();
    hold(1'b1, 1'b1, 12);
    hold(1'b1, 1'b0, 12);
    cur_sda = 1'b0;
    if (e_start != e_stop + e_rstart) e_rstart++;
    e_start++;
  endtask

  task automatic do_stop(input int len);
    low_phase(len, 1'b0, 1'b1);
    hold(1'b1, 1'b0, 12);
    hold(1'b1, 1'b1, 12);
    cur_sda = 1'b1;
    e_stop++;
  endtask

  task automatic send_byte(input int lows[9]);
    for (int i = 0; i < 9; i++) begin
      low_phase(lows[i], 1'($urandom_range(0, 1)), i == 0);
      hold(1'b1, cur_sda, $urandom_range(12, 20));
    end
    if (over(m_cur, MEXT)) e_mext = 1;
    m_cur = 0;
  endtask

  task automatic rand_byte();
    int lows[9];
    lows[0] = $urandom_range(20, 130);
    for (int i = 1; i < 9; i++) lows[i] = $urandom_range(20, 45);
    send_byte(lows);
  endtask

  task automatic fixed_byte(input int mlen, input int last);
    int lows[9];
    lows[0] = 20;
    for (int i = 1; i < 9; i++) lows[i] = mlen;
    lows[8] = last;
    send_byte(lows);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    s_tot = 0; m_cur = 0; e_mext = 0;
  endtask

  task automatic check_msg(input string tag);
    repeat (10) @(negedge clk);
    check({tag, " R6 sext"}, sext_flag, over(s_tot, SEXT));
    check({tag, " R7 mext"}, mext_flag, e_mext);
    check({tag, " R5 no timeout"}, timeout_flag, 0);
    check({tag, " R8 no slow"}, slow_flag, 0);
    check({tag, " R4 busy released"}, bus_busy, 0);
    check({tag, " R2 start count"}, n_start, e_start);
    check({tag, " R3 rstart count"}, n_rstart, e_rstart);
    check({tag, " R4 stop count"}, n_stop, e_stop);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    check("R11 busy", bus_busy, 0);
    check("R11 idle", idle, 0);
    check("R11 flags", {timeout_flag, sext_flag, mext_flag, slow_flag}, 0);
    check("R11 pulses", {start_pulse, rstart_pulse, stop_pulse}, 0);
    rst_n = 1'b1;
    hold(1'b1, 1'b1, 90);
    check("R9 idle not yet", idle, 0);
    hold(1'b1, 1'b1, 30);
    check("R9 idle after window", idle, 1);
    check("R8 no slow on free bus", slow_flag, 0);

    hold(1'b1, 1'b0, 1);
    hold(1'b1, 1'b1, 20);
    hold(1'b0, 1'b1, 1);
    hold(1'b1, 1'b1, 20);
    check("R1 glitch gives no start", n_start, 0);
    check("R1 glitch keeps idle", idle, 1);

    do_start();
    check("R9 idle drops", idle, 0);
    check("R2 busy after start", bus_busy, 1);
    fixed_byte(35, 35);
    do_stop(20);
    check_msg("directed byte stretch 120");
    clear_flags();

    do_start();
    fixed_byte(35, 36);
    do_stop(20);
    check_msg("directed byte stretch 121");
    clear_flags();
    check("R10 clr clears mext", mext_flag, 0);

    do_start();
    low_phase(110, 1'b1, 1'b1);
    do_start();
    low_phase(110, 1'b1, 1'b1);
    do_start();
    do_stop(100);
    check_msg("directed rstart keeps total");
    check("R6 sext across rstart", sext_flag, 1);
    repeat (30) @(negedge clk);
    check("R10 sext held", sext_flag, 1);
    clear_flags();

    do_start();
    low_phase(25, 1'b0, 1'b1);
    hold(1'b1, 1'b0, 170);
    check("R8 slow high phase", slow_flag, 1);
    do_stop(25);
    clear_flags();
    check("R10 clr clears slow", slow_flag, 0);
    do_start();
    low_phase(170, 1'b0, 1'b1);
    check("R8 slow low phase", slow_flag, 1);
    check("R5 no timeout below limit", timeout_flag, 0);
    hold(1'b1, 1'b0, 12);
    hold(1'b1, 1'b1, 12);
    e_stop++;
    clear_flags();

    do_start();
    hold(1'b0, 1'b0, 320);
    check("R5 timeout set", timeout_flag, 1);
    check("R5 busy dropped", bus_busy, 0);
    check("R5 idle pending", idle, 0);
    hold(1'b1, 1'b1, 60);
    check("R5 idle needs new window", idle, 0);
    hold(1'b1, 1'b1, 60);
    check("R9 idle after timeout", idle, 1);
    check("R10 timeout held", timeout_flag, 1);
    clear_flags();
    check("R10 clr clears timeout", timeout_flag, 0);
    n_start = 0; n_rstart = 0; n_stop = 0;
    e_start = 0; e_rstart = 0; e_stop = 0;

    for (int m = 0; m < 20; m++) begin
      do_start();
      repeat ($urandom_range(1, 3)) rand_byte();
      if ($urandom_range(0, 1) == 1) begin
        low_phase($urandom_range(20, 130), 1'b1, 1'b1);
        do_start();
        repeat ($urandom_range(1, 2)) rand_byte();
      end
      do_stop($urandom_range(20, 130));
      check_msg("random message");
      clear_flags();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule